// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the microinstruction address of a microcoded controller and decides, every clock, which control-store word comes next. Each microword carries three branch-control bits, a literal next-address field and a five-bit mask. The controller also presents an eight-bit value from its internal bus, which is either the opcode or the condition codes.

From these inputs the sequencer does one of five things. It can step to the following address. It can jump to the literal. It can jump to a target built from the literal and the masked bus bits, which gives a multiway dispatch. It can call a subroutine, saving the return address in a one-deep holding register. It can return through that register.

Dispatch tables are built by placing a block of jump words at a literal base whose low bits are zero. The mask then opens as many low address bits to the bus as the table has entries. An opcode table uses four or five bits. A condition-code table uses two bits: codes 00 and 01 land on fall-through words, and codes 10 and 11 land on branch words. The control-store contents and the datapath lie outside the block.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `uaddr` and `ret_addr` both become zero on that edge.
- R2: Branch control `3'b000` (order {lit_only, lit_en, hold_sel}) loads `uaddr + 1`, and address 1023 wraps to 0.
- R3: Branch control `3'b110` loads `lit_addr` into `uaddr`.
- R4: Branch control `3'b010` loads a merged target. Each address bit i below 5 is `lit_addr[i] | (lit_mask[i] & disp_bus[i])`, and each address bit from 5 up equals `lit_addr`.
- R5: In a `3'b010` jump, a bus bit whose mask bit is 0 has no effect on the target.
- R6: Branch control `3'b101` loads `ret_addr` into `uaddr`, and `ret_addr` keeps its value.
- R7: Branch control `3'b111` loads `lit_addr` into `uaddr` and stores `uaddr + 1` (wrapping) into `ret_addr`.
- R8: No branch-control value other than `3'b111` changes `ret_addr`.
- R9: The unassigned codes `3'b001`, `3'b011` and `3'b100` act like `3'b000`.
- R10: Bus bits 5 to 7 never influence the next address, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_ctl | input | 3 | Branch control {lit_only, lit_en, hold_sel} |
| lit_addr | input | 10 | Literal next-address field of the microword |
| lit_mask | input | 5 | Selects the low address bits taken from the bus in a conditional jump |
| disp_bus | input | 8 | Runtime dispatch value (opcode or condition codes) |
| uaddr | output | 10 | Current microinstruction address |
| ret_addr | output | 10 | One-deep subroutine return address |

## Verification
The bench uses the default parameters: a 10-bit address, a 5-bit mask and an 8-bit bus. At that size the wrap from 1023 to 0 is reached by a single literal jump followed by one step or one call. Bus bits 5 to 7 exist, so a dispatch can be fed values that are wider than the mask. A two-bit mask against a base of 0x0DC walks the whole condition-code table, and a four-bit mask against a base of 0x300 exercises opcode dispatch, including a literal bit that is already set under an open mask.

// File: rtl/useq_pkg.sv
// Package: shared types and branch-control encodings for the microsequencer.
// Assumes the branch-control field is ordered {lit_only, lit_en, hold_sel}.
package useq_pkg;

    typedef enum logic [2:0] {
        OP_SEQ      = 3'd0,
        OP_JUMP     = 3'd1,
        OP_DISPATCH = 3'd2,
        OP_RETURN   = 3'd3,
        OP_CALL     = 3'd4
    } useq_op_e;

    localparam logic [2:0] CTL_SEQ      = 3'b000;
    localparam logic [2:0] CTL_JUMP     = 3'b110;
    localparam logic [2:0] CTL_DISPATCH = 3'b010;
    localparam logic [2:0] CTL_RETURN   = 3'b101;
    localparam logic [2:0] CTL_CALL     = 3'b111;

endpackage

// File: rtl/useq_decode.sv
// Module: useq_decode
// Maps the three branch-control bits onto a sequencer operation.
// Assumes unassigned codes should fall back to a plain step.
module useq_decode
    import useq_pkg::*;
(
    input  logic [2:0] br_ctl,
    output useq_op_e   op
);

    // Purpose: one-hot-free case decode with a safe default.
    always_comb begin
        unique case (br_ctl)
            CTL_JUMP:     op = OP_JUMP;
            CTL_DISPATCH: op = OP_DISPATCH;
            CTL_RETURN:   op = OP_RETURN;
            CTL_CALL:     op = OP_CALL;
            default:      op = OP_SEQ;
        endcase
    end

endmodule

// File: rtl/useq_merge.sv
// Module: useq_merge
// Builds the conditional-jump target by ORing masked bus bits into the
// literal's low bits. Assumes MASK_W <= ADDR_W; bus bits at or above
// MASK_W (or beyond BUS_W) are never used.
module useq_merge #(
    parameter int ADDR_W = 10,
    parameter int MASK_W = 5,
    parameter int BUS_W  = 8
) (
    input  logic [ADDR_W-1:0] lit_addr,
    input  logic [MASK_W-1:0] lit_mask,
    input  logic [BUS_W-1:0]  disp_bus,
    output logic [ADDR_W-1:0] target
);

    // Purpose: per-bit choice between pure literal and literal OR bus bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < MASK_W && i < BUS_W) begin : g_open
            assign target[i] = lit_addr[i] | (lit_mask[i] & disp_bus[i]);
        end else begin : g_lit
            assign target[i] = lit_addr[i];
        end
    end

endmodule

// File: rtl/useq_hold.sv
// Module: useq_hold
// One-deep return-address holding register. Loads only on a call.
// Assumes the synchronous active-low reset clears it.
module useq_hold #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Purpose: capture the return address on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R8: the register changes only when loaded
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/useq_core.sv
// Module: useq_core (top)
// Microprogram next-address sequencer: step, literal jump, masked
// dispatch, call and return. Assumes synchronous active-low reset and
// that control-store words are presented combinationally for uaddr.
module useq_core
    import useq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int MASK_W = 5,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        br_ctl,
    input  logic [ADDR_W-1:0] lit_addr,
    input  logic [MASK_W-1:0] lit_mask,
    input  logic [BUS_W-1:0]  disp_bus,
    output logic [ADDR_W-1:0] uaddr,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    useq_op_e          op;
    logic [ADDR_W-1:0] incr_addr;
    logic [ADDR_W-1:0] merge_addr;
    logic [ADDR_W-1:0] next_addr;

    useq_decode u_decode (
        .br_ctl (br_ctl),
        .op     (op)
    );

    useq_merge #(
        .ADDR_W (ADDR_W),
        .MASK_W (MASK_W),
        .BUS_W  (BUS_W)
    ) u_merge (
        .lit_addr (lit_addr),
        .lit_mask (lit_mask),
        .disp_bus (disp_bus),
        .target   (merge_addr)
    );

    useq_hold #(
        .ADDR_W (ADDR_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (op == OP_CALL),
        .d     (incr_addr),
        .q     (ret_addr)
    );

    // Purpose: sequential successor, wrapping at the top of the store.
    assign incr_addr = uaddr + ONE;

    // Purpose: select the next microaddress from the decoded operation.
    always_comb begin
        unique case (op)
            OP_JUMP,
            OP_CALL:     next_addr = lit_addr;
            OP_DISPATCH: next_addr = merge_addr;
            OP_RETURN:   next_addr = ret_addr;
            default:     next_addr = incr_addr;
        endcase
    end

    // Purpose: microaddress register, zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) uaddr <= '0;
        else        uaddr <= next_addr;
    end

    // R1: reset clears both registers
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (uaddr == '0 && ret_addr == '0));

    // R2: step advances by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ctl == CTL_SEQ) |=> uaddr == $past(uaddr) + ONE);

    // R3: literal jump
    a_r3_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ctl == CTL_JUMP) |=> uaddr == $past(lit_addr));

    // R4: dispatch keeps the literal's upper bits
    a_r4_dispatch_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ctl == CTL_DISPATCH)
        |=> uaddr[ADDR_W-1:MASK_W] == $past(lit_addr[ADDR_W-1:MASK_W]));

    // R5: a closed mask gives the literal unchanged
    a_r5_closed_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ctl == CTL_DISPATCH && lit_mask == '0) |=> uaddr == $past(lit_addr));

    // R6: return uses the saved address
    a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ctl == CTL_RETURN) |=> uaddr == $past(ret_addr));

    // R7: call saves the successor and jumps
    a_r7_call: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ctl == CTL_CALL)
        |=> (ret_addr == $past(uaddr) + ONE && uaddr == $past(lit_addr)));

    // R9: unassigned codes step like 000
    a_r9_spare_step: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ctl == 3'b001 || br_ctl == 3'b011 || br_ctl == 3'b100)
        |=> uaddr == $past(uaddr) + ONE);

endmodule

// File: tb/tb_useq_core.sv
module tb_useq_core;

    localparam int AW = 10;
    localparam int MW = 5;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    br_ctl = 3'b000;
    logic [AW-1:0] lit_addr = '0;
    logic [MW-1:0] lit_mask = '0;
    logic [BW-1:0] disp_bus = '0;
    logic [AW-1:0] uaddr;
    logic [AW-1:0] ret_addr;

    int n_checks = 0;
    int n_fail   = 0;
    logic [AW-1:0] m_addr;
    logic [AW-1:0] m_ret;

    always #4 clk = ~clk;

    useq_core #(.ADDR_W(AW), .MASK_W(MW), .BUS_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .br_ctl(br_ctl), .lit_addr(lit_addr),
        .lit_mask(lit_mask), .disp_bus(disp_bus), .uaddr(uaddr), .ret_addr(ret_addr)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
        end
    endtask

    // drive one microword, clock it, sample 2 ns after the edge
    task automatic step(input logic [2:0] c, input logic [AW-1:0] l,
                        input logic [MW-1:0] m, input logic [BW-1:0] b);
        br_ctl = c; lit_addr = l; lit_mask = m; disp_bus = b;
        @(posedge clk); #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3'b110, 10'h155, 5'h1F, 8'hFF);
        check("R1 uaddr", uaddr, '0);
        check("R1 ret_addr", ret_addr, '0);
        rst_n = 1'b1;
        m_addr = '0; m_ret = '0;
    endtask

    task automatic t_step();
        for (int k = 0; k < 3; k++) begin
            step(3'b000, 10'h3FF, 5'h1F, 8'hFF);
            m_addr = m_addr + 1'b1;
            check("R2 step", uaddr, m_addr);
        end
        step(3'b110, 10'h3FF, 5'h00, 8'h00);
        check("R3 jump to top", uaddr, 10'h3FF);
        step(3'b000, 10'h000, 5'h00, 8'h00);
        check("R2 wrap", uaddr, 10'h000);
        m_addr = 10'h000;
    endtask

    task automatic t_jump();
        step(3'b110, 10'h2A5, 5'h1F, 8'hFF);
        check("R3 jump", uaddr, 10'h2A5);
        m_addr = 10'h2A5;
    endtask

    task automatic t_dispatch();
        step(3'b010, 10'h300, 5'b01111, 8'h0B);
        check("R4 opcode dispatch", uaddr, 10'h30B);
        step(3'b010, 10'h300, 5'b01111, 8'h1F);
        check("R5 masked-off bit 4", uaddr, 10'h30F);
        step(3'b010, 10'h305, 5'h1F, 8'h02);
        check("R4 literal OR bus", uaddr, 10'h307);
        step(3'b010, 10'h300, 5'b00000, 8'hFF);
        check("R5 closed mask", uaddr, 10'h300);
        step(3'b010, 10'h300, 5'h1F, 8'hE3);
        check("R10 high bus bits", uaddr, 10'h303);
        for (int cc = 0; cc < 4; cc++) begin
            step(3'b010, 10'h0DC, 5'b00011, BW'(cc) | 8'hFC);
            check("R4 cc table", uaddr, 10'h0DC | AW'(cc));
        end
        m_addr = 10'h0DF;
        check("R8 ret after dispatch", ret_addr, m_ret);
    endtask

    task automatic t_call_return();
        step(3'b111, 10'h150, 5'h1F, 8'hFF);
        m_ret = m_addr + 1'b1;
        check("R7 call target", uaddr, 10'h150);
        check("R7 saved return", ret_addr, m_ret);
        step(3'b000, 10'h000, 5'h00, 8'h00);
        step(3'b110, 10'h077, 5'h00, 8'h00);
        check("R8 ret held", ret_addr, m_ret);
        step(3'b101, 10'h222, 5'h1F, 8'hFF);
        check("R6 return", uaddr, m_ret);
        check("R6 ret kept", ret_addr, m_ret);
        m_addr = m_ret;
        step(3'b110, 10'h3FF, 5'h00, 8'h00);
        step(3'b111, 10'h005, 5'h00, 8'h00);
        check("R7 call wrap target", uaddr, 10'h005);
        check("R7 call wrap ret", ret_addr, 10'h000);
        m_addr = 10'h005; m_ret = 10'h000;
    endtask

    task automatic t_spare();
        logic [2:0] codes [3];
        codes[0] = 3'b001; codes[1] = 3'b011; codes[2] = 3'b100;
        for (int k = 0; k < 3; k++) begin
            step(codes[k], 10'h3A0, 5'h1F, 8'hFF);
            m_addr = m_addr + 1'b1;
            check("R9 spare code steps", uaddr, m_addr);
            check("R8 spare code ret", ret_addr, m_ret);
        end
    endtask

    task automatic t_midreset();
        step(3'b111, 10'h123, 5'h00, 8'h00);
        rst_n = 1'b0;
        step(3'b111, 10'h321, 5'h00, 8'h00);
        check("R1 mid-run uaddr", uaddr, '0);
        check("R1 mid-run ret", ret_addr, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        #1;
        t_reset();
        t_step();
        t_jump();
        t_dispatch();
        t_call_return();
        t_spare();
        t_midreset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #80000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule